// File: doc/BRIEF.md
# SPI Master Bit-Rate Generator

This block makes the serial bit clock for an SPI master from the bus clock. The bus clock is divided in two stages. The first is a linear prescaler that divides by 1 to 8. The second is a power-of-two stage that divides by 2 to 512. The overall divisor is (prescale + 1) × 2^(rate + 1), so the serial clock runs at the bus clock frequency divided by that product. The output is a 50% duty serial clock. Two single-cycle strobes mark its leading (rising) and trailing (falling) edges, so the shifter can sample and shift without detecting edges itself.

To save power, the counters run only while the block is in master mode and a transfer is in progress. At all other times both stages are held at zero and the serial clock idles low, so every transfer begins with a full first half period. The divide fields are captured while the generator is idle and held for the whole transfer. A change made mid-transfer therefore takes effect at the next transfer. Rate codes above 8 are reserved and divide as code 8.

Top module: `spibrg_top`

## Requirements
- R1: After reset, sclkOut, leadStrobe and trailStrobe are all 0.
- R2: While masterMode or xferActive is 0, all three outputs stay 0 from the cycle after the first edge that sees it.
- R3: Let H = (prescaleSel + 1) × 2^rateSel, where prescaleSel is unsigned 3-bit and rateSel is unsigned 4-bit. When the generator is enabled, the first rising edge of sclkOut appears after exactly H enabled clock edges.
- R4: sclkOut toggles once every H clock edges, giving a 50% duty clock whose period is the full divisor 2H, for every prescaleSel value 0 to 7 and rateSel value 0 to 8.
- R5: leadStrobe is high for exactly the first cycle in which sclkOut is high after a rise. trailStrobe is high for exactly the first cycle in which sclkOut is low after a fall that happens while enabled.
- R6: rateSel values 9 to 15 are reserved and divide exactly as rateSel = 8.
- R7: Changing prescaleSel or rateSel while a transfer is active does not change the clock of that transfer.
- R8: When the enable drops, sclkOut returns to 0 one cycle later. A following transfer again starts with a full first half period.
- R9: leadStrobe and trailStrobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prescaleSel | input | 3 | Linear prescale code; divides by code + 1 |
| rateSel | input | 4 | Power-of-two rate code; divides by 2^(code + 1); codes above 8 are reserved |
| masterMode | input | 1 | High when the SPI operates as master |
| xferActive | input | 1 | High while a serial transfer is in progress |
| sclkOut | output | 1 | Divided serial clock, idles low |
| leadStrobe | output | 1 | One-cycle pulse in the first cycle after sclkOut rises |
| trailStrobe | output | 1 | One-cycle pulse in the first cycle after sclkOut falls |

## Verification
All outputs are registered. If the first enabled edge is counted as edge 1, edge k belongs to one of two cases. When k is not a multiple of H, sclkOut stays at its current value. When k is a multiple of H, the bench expects sclkOut at (k/H) mod 2 and one of the two strobes high in the half cycle after edge k. The bench drives inputs on the falling edge and samples on the next falling edge, so each sample follows exactly one rising edge. For a disable, it expects all outputs at 0 one sample later. Field changes made mid-transfer are checked by keeping the expected H fixed at its value from the start of the transfer.

// File: rtl/spibrg_pkg.sv
package spibrg_pkg;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic run;       // generator enabled this cycle
    logic stepRate;  // prescaler completed one count period
  } brgStrobe_t;

endpackage

// File: rtl/spibrg_ctrl.sv
module spibrg_ctrl
  import spibrg_pkg::*;
#(
  parameter int PRE_W    = 3,
  parameter int RATE_W   = 4,
  parameter int RATE_MAX = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PRE_W-1:0]    prescaleSel,
  input  logic [RATE_W-1:0]   rateSel,
  input  logic                masterMode,
  input  logic                xferActive,
  output brgStrobe_t          strobe,
  output logic [RATE_MAX-1:0] rateLast
);

  localparam logic [RATE_W-1:0] RATE_CAP = RATE_W'(RATE_MAX);

  logic                run;
  logic [PRE_W-1:0]    preLast;
  logic [PRE_W-1:0]    preCnt;
  logic [RATE_W-1:0]   rateEff;
  logic [RATE_MAX-1:0] rateMaskNext;

  assign run     = masterMode & xferActive;
  assign rateEff = (rateSel > RATE_CAP) ? RATE_CAP : rateSel;

  // terminal count of the rate stage: 2^rateEff - 1 as a thermometer mask
  for (genvar gi = 0; gi < RATE_MAX; gi++) begin : g_mask
    assign rateMaskNext[gi] = (rateEff > RATE_W'(gi));
  end

  // fields are captured only while idle and frozen during a transfer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preLast  <= '0;
      rateLast <= '0;
    end else if (!run) begin
      preLast  <= prescaleSel;
      rateLast <= rateMaskNext;
    end
  end

  // linear prescaler, held at zero while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!run) begin
      preCnt <= '0;
    end else if (preCnt == preLast) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign strobe.run      = run;
  assign strobe.stepRate = run && (preCnt == preLast);

endmodule

// File: rtl/spibrg_datapath.sv
module spibrg_datapath
  import spibrg_pkg::*;
#(
  parameter int RATE_MAX = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  brgStrobe_t          strobe,
  input  logic [RATE_MAX-1:0] rateLast,
  output logic                sclkOut,
  output logic                leadStrobe,
  output logic                trailStrobe
);

  logic [RATE_MAX-1:0] rateCnt;
  logic                halfDone;

  assign halfDone = strobe.stepRate && (rateCnt == rateLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateCnt     <= '0;
      sclkOut     <= 1'b0;
      leadStrobe  <= 1'b0;
      trailStrobe <= 1'b0;
    end else if (!strobe.run) begin
      rateCnt     <= '0;
      sclkOut     <= 1'b0;
      leadStrobe  <= 1'b0;
      trailStrobe <= 1'b0;
    end else begin
      leadStrobe  <= halfDone && !sclkOut;
      trailStrobe <= halfDone && sclkOut;
      if (halfDone) begin
        rateCnt <= '0;
        sclkOut <= ~sclkOut;
      end else if (strobe.stepRate) begin
        rateCnt <= rateCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spibrg_top.sv
module spibrg_top
  import spibrg_pkg::*;
#(
  parameter int PRE_W    = 3,
  parameter int RATE_W   = 4,
  parameter int RATE_MAX = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRE_W-1:0]  prescaleSel,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              masterMode,
  input  logic              xferActive,
  output logic              sclkOut,
  output logic              leadStrobe,
  output logic              trailStrobe
);

  brgStrobe_t          strobe;
  logic [RATE_MAX-1:0] rateLast;

  spibrg_ctrl #(
    .PRE_W(PRE_W), .RATE_W(RATE_W), .RATE_MAX(RATE_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .prescaleSel(prescaleSel), .rateSel(rateSel),
    .masterMode(masterMode), .xferActive(xferActive),
    .strobe(strobe), .rateLast(rateLast)
  );

  spibrg_datapath #(
    .RATE_MAX(RATE_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .rateLast(rateLast),
    .sclkOut(sclkOut), .leadStrobe(leadStrobe), .trailStrobe(trailStrobe)
  );

endmodule

// File: rtl/spibrg_checker.sv
module spibrg_checker (
  input logic clk,
  input logic rstN,
  input logic masterMode,
  input logic xferActive,
  input logic sclkOut,
  input logic leadStrobe,
  input logic trailStrobe
);

  // R2: idle generator is silent one cycle later
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(masterMode && xferActive) |=> (!sclkOut && !leadStrobe && !trailStrobe));

  // R5: lead strobe marks a rise
  a_r5_lead_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    leadStrobe |-> (sclkOut && !$past(sclkOut)));

  // R5: trail strobe marks a fall
  a_r5_trail_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    trailStrobe |-> (!sclkOut && $past(sclkOut)));

  // R4: while running, the clock only changes together with a strobe
  a_r4_toggle_strobed: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sclkOut) && $past(masterMode && xferActive)) |-> (leadStrobe || trailStrobe));

  // R9: strobes are exclusive
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(leadStrobe && trailStrobe));

endmodule

bind spibrg_top spibrg_checker u_chk (
  .clk(clk), .rstN(rstN),
  .masterMode(masterMode), .xferActive(xferActive),
  .sclkOut(sclkOut), .leadStrobe(leadStrobe), .trailStrobe(trailStrobe)
);

// File: tb/spibrg_top_tb.sv
module spibrg_top_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] prescaleSel = '0;
  logic [3:0] rateSel = '0;
  logic       masterMode = 1'b0;
  logic       xferActive = 1'b0;
  logic       sclkOut, leadStrobe, trailStrobe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spibrg_top u_dut (
    .clk(clk), .rstN(rstN),
    .prescaleSel(prescaleSel), .rateSel(rateSel),
    .masterMode(masterMode), .xferActive(xferActive),
    .sclkOut(sclkOut), .leadStrobe(leadStrobe), .trailStrobe(trailStrobe)
  );

  task automatic checkIdle(input string req);
    checks++;
    if ({sclkOut, leadStrobe, trailStrobe} !== 3'b000) begin
      errors++;
      $display("FAIL %s idle outputs actual=%b expected=000", req,
               {sclkOut, leadStrobe, trailStrobe});
    end
  endtask

  // one transfer of n enabled edges; fields optionally changed after edge chgAt
  task automatic runXfer(input int p, input int r, input int n, input int chgAt,
                         input string req);
    int rEff = (r > 8) ? 8 : r;
    int h = (p + 1) << rEff;
    int bad = 0;
    logic [2:0] act, expv;
    prescaleSel = 3'(p);
    rateSel     = 4'(r);
    masterMode  = 1'b1;
    xferActive  = 1'b0;
    repeat (2) @(negedge clk);
    xferActive = 1'b1;
    for (int k = 1; k <= n; k++) begin
      int q;
      logic edgeHit;
      @(negedge clk);
      q = k / h;
      edgeHit = (k % h) == 0;
      act  = {sclkOut, leadStrobe, trailStrobe};
      expv = {(q % 2) == 1, edgeHit && (q % 2) == 1, edgeHit && (q % 2) == 0};
      if (act !== expv) begin
        if (bad == 0)
          $display("FAIL %s p=%0d r=%0d edge %0d actual=%b expected=%b",
                   req, p, r, k, act, expv);
        bad++;
      end
      if (k == chgAt) begin
        prescaleSel = 3'd0;
        rateSel     = 4'd0;
      end
    end
    checks++;
    if (bad != 0) errors++;
    xferActive = 1'b0;
    @(negedge clk);
    checkIdle("R8 stop");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1");

    // R2: either enable condition missing keeps the clock quiet
    masterMode = 1'b0; xferActive = 1'b1;
    begin
      int bad = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if ({sclkOut, leadStrobe, trailStrobe} !== 3'b000) bad++;
      end
      masterMode = 1'b1; xferActive = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if ({sclkOut, leadStrobe, trailStrobe} !== 3'b000) bad++;
      end
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL R2 active cycles actual=%0d expected=0", bad);
      end
    end

    // R3 R4 R5: full sweep of legal fields
    for (int p = 0; p < 8; p++)
      for (int r = 0; r <= 8; r++)
        runXfer(p, r, 4 * ((p + 1) << r) + 2, 0, "R3 R4 R5");

    // R6: reserved rate codes divide as code 8
    runXfer(0, 9, 4 * 256 + 2, 0, "R6");
    runXfer(0, 15, 4 * 256 + 2, 0, "R6");
    runXfer(1, 12, 2 * 512 + 2, 0, "R6");

    // R7: mid-transfer field change is ignored
    runXfer(1, 1, 30, 2, "R7");
    runXfer(3, 2, 70, 5, "R7");

    // R8: stop mid-period, restart gives a full first half period
    runXfer(3, 2, 23, 0, "R8");
    runXfer(3, 2, 40, 0, "R8");
    runXfer(0, 0, 3, 0, "R8");
    runXfer(0, 0, 9, 0, "R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule